// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Control Interface

This block is the digital side of a single-channel measurement converter. A host talks to it over three wires: an active-low select, a serial clock and a data input. A fourth line, the data output, carries register contents during reads. Between reads it carries an active-low ready flag. Every transaction opens with an 8-bit command byte. The command names a register, says whether the next phase reads it or writes it, picks the analog channel and can switch the link into a streaming mode. The converter core is modelled outside the block. It hands over a finished result with a one-cycle strobe, and the block keeps that result in its data register.

All serial inputs are brought into the system clock domain through two-flop synchronizers. A data bit is taken on each rising serial-clock edge, and data goes out most significant bit first. The output advances right after the rising edge it was sampled on, so the host samples on the rising edge. The controller has four states:
- `ST_CMD` waits for a command.
- `ST_WR` takes in one write byte.
- `ST_RD` shifts out one register.
- `ST_CONT` streams the data register word after word.

The transitions are:
- `ST_CMD` goes to `ST_RD` on a read command, to `ST_WR` on a write command to a register other than 00, and to `ST_CONT` on the streaming command.
- `ST_WR` and `ST_RD` go back to `ST_CMD` after their last bit, or when select is released.
- `ST_CONT` goes back to `ST_CMD` on the exit command.
- Any state goes to `ST_CMD` on the resync reset.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After reset the mode register reads 0x00 and the channel output is 00. The status byte reads 0x88: bit 7 is the ready flag (1 = not ready), bit 3 is 1 for a 24-bit result, bits 1:0 are the channel and the other bits are 0. While select is high, `dout_oe` is 0. While select is low and no read is in progress, `dout` shows the ready flag.
- R2: In `ST_CMD`, a 1 clocked in as the first command bit is discarded, and the interface keeps waiting at that position until a 0 arrives. That 0 and the next seven bits then form the command.
- R3: Command bit fields, from bit 7 down, are: write-enable (0), fixed 0, register select [5:4], read (bit 3 = 1), streaming (bit 2) and channel [1:0]. On a read, select 00 returns the 8-bit status, 01 the 8-bit mode register, 10 eight zero bits and 11 the DATA_W-bit data register.
- R4: A write command with select 01 takes the next 8 bits into the mode register, which then appears on `mode_cfg` and reads back unchanged. A write with select 00 has no data phase.
- R5: Every command loads its channel bits into `chan_sel`. `chan_restart` pulses for one cycle only when the value changes.
- R6: A `conv_done` strobe latches `conv_result` and drives the ready flag low. A data-register read returns the word most significant bit first. When the read completes, the ready flag goes high.
- R7: A result that arrives while the data register is being shifted out is held back. The read in progress returns the old word. The new word is latched when the read ends, so the flag is low again and the next read returns the new word.
- R8: The command 001111xx enters `ST_CMD`→`ST_CONT`. In that state, each time the ready flag is low, the next DATA_W clocks shift out the data register with no command. Each completed word drives the flag high.
- R9: In `ST_CONT`, the byte 001110xx clocked in on the data input during the first 8 clocks of a word returns the block to `ST_CMD`. Those clocks only happen while the flag is low. The interrupted word does not drive the flag high.
- R10: 32 consecutive 1s sampled on the data input reset every register and the state to their reset values, in any state.
- R11: Raising select in the middle of a command abandons it, and the next command starts again at its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cs_n | input | 1 | serial select, active low |
| sclk | input | 1 | serial clock, idles low, data taken on rising edge |
| din | input | 1 | serial data input |
| dout | output | 1 | serial data output / active-low ready flag |
| dout_oe | output | 1 | output enable for `dout` (0 = high impedance) |
| conv_done | input | 1 | one-cycle strobe: new conversion result valid |
| conv_result | input | DATA_W | conversion result, offset binary |
| mode_cfg | output | 8 | mode register contents |
| chan_sel | output | 2 | selected channel: 00 differential, 10 short, 11 supply monitor |
| chan_restart | output | 1 | one-cycle pulse when the channel changes |

## Verification
A serial-clock rising edge takes effect two to three system cycles after the pin changes, because of the synchronizer and the edge register. The output bit or state change that follows appears one cycle after that. The bench holds each serial-clock phase for six cycles and samples `dout` at the end of the low phase, just before the rise that consumes the bit, so every read bit and every ready-flag level has settled. A `conv_done` pulse moves the ready flag on the next cycle. Streaming reloads its word one cycle later, and the bench waits several cycles before clocking.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2,
        ST_CONT = 2'd3
    } if_state_t;

    localparam logic [1:0] RS_STAT = 2'b00;
    localparam logic [1:0] RS_MODE = 2'b01;
    localparam logic [1:0] RS_RSVD = 2'b10;
    localparam logic [1:0] RS_DATA = 2'b11;
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_act,
    output logic din_s,
    output logic bit_rise
);
    logic sclk_m, sclk_s, sclk_p;
    logic cs_m, cs_s;
    logic din_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_m <= 1'b0;
            sclk_s <= 1'b0;
            sclk_p <= 1'b0;
            cs_m   <= 1'b1;
            cs_s   <= 1'b1;
            din_m  <= 1'b0;
            din_s  <= 1'b0;
        end else begin
            sclk_m <= sclk;
            sclk_s <= sclk_m;
            sclk_p <= sclk_s;
            cs_m   <= cs_n;
            cs_s   <= cs_m;
            din_m  <= din;
            din_s  <= din_m;
        end
    end

    assign cs_act   = ~cs_s;
    assign bit_rise = sclk_s & ~sclk_p & ~cs_s;
endmodule

// File: rtl/adc_run_detect.sv
module adc_run_detect #(
    parameter int RUN_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic bit_val,
    output logic fire_q
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(RUN_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (stb) begin
                if (!bit_val) begin
                    cnt_q <= '0;
                end else if (cnt_q == CNT_TOP) begin
                    cnt_q  <= '0;
                    fire_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R10
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(RUN_LEN));

    // R10
    fire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> (cnt_q == '0));
endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    input  logic              hold,
    input  logic              read_done,
    output logic [DATA_W-1:0] data_q,
    output logic              rdy_n
);
    logic [DATA_W-1:0] pend_q;
    logic              pend_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            pend_q <= '0;
            pend_v <= 1'b0;
            rdy_n  <= 1'b1;
        end else if (srst) begin
            data_q <= '0;
            pend_q <= '0;
            pend_v <= 1'b0;
            rdy_n  <= 1'b1;
        end else if (conv_done && !hold) begin
            data_q <= conv_result;
            pend_v <= 1'b0;
            rdy_n  <= 1'b0;
        end else if (conv_done) begin
            pend_q <= conv_result;
            pend_v <= 1'b1;
            if (read_done) rdy_n <= 1'b1;
        end else if (pend_v && !hold) begin
            data_q <= pend_q;
            pend_v <= 1'b0;
            rdy_n  <= 1'b0;
        end else if (read_done) begin
            rdy_n <= 1'b1;
        end
    end

    // R6
    new_result_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !hold && !srst) |=> !rdy_n);

    // R7
    held_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !srst) |=> $stable(data_q));
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
    import adc_if_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int RUN_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    output logic [7:0]        mode_cfg,
    output logic [1:0]        chan_sel,
    output logic              chan_restart
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(7);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(DATA_W - 1);
    localparam logic WIDE = (DATA_W > 16);
    localparam int PAD_W = DATA_W - 8;

    logic cs_act, din_s, bit_rise, srst;
    logic [DATA_W-1:0] data_q;
    logic rdy_n, hold, read_done;

    if_state_t         state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q, last_q;
    logic [1:0]        sel_q, chan_q;
    logic [6:0]        cmd_sh_q;
    logic [DATA_W-1:0] shift_q;
    logic              live_q, restart_q;
    logic [7:0]        mode_q;

    logic [7:0] byte_in, status_b;
    logic       at_last, cont_enter, cont_exit;
    logic [DATA_W-1:0] load_val;

    adc_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .cs_act(cs_act), .din_s(din_s), .bit_rise(bit_rise)
    );

    adc_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
        .clk(clk), .rst_n(rst_n), .stb(bit_rise), .bit_val(din_s), .fire_q(srst)
    );

    adc_result_latch #(.DATA_W(DATA_W)) u_res (
        .clk(clk), .rst_n(rst_n), .srst(srst), .conv_done(conv_done),
        .conv_result(conv_result), .hold(hold), .read_done(read_done),
        .data_q(data_q), .rdy_n(rdy_n)
    );

    assign byte_in    = {cmd_sh_q, din_s};
    assign status_b   = {rdy_n, 3'b000, WIDE, 1'b0, chan_q};
    assign at_last    = (bit_cnt_q == last_q);
    assign cont_enter = byte_in[3] && (byte_in[5:4] == RS_DATA) && byte_in[2];
    assign cont_exit  = (state_q == ST_CONT) && live_q && bit_rise &&
                        (bit_cnt_q == LAST_BYTE) && (byte_in[7:2] == 6'b001110);
    assign hold       = ((state_q == ST_RD) && (sel_q == RS_DATA)) ||
                        ((state_q == ST_CONT) && live_q);
    assign read_done  = bit_rise && !cont_exit &&
                        (((state_q == ST_RD) && (sel_q == RS_DATA) && at_last) ||
                         ((state_q == ST_CONT) && live_q && (bit_cnt_q == LAST_WORD)));

    always_comb begin
        unique case (byte_in[5:4])
            RS_STAT: load_val = {status_b, {PAD_W{1'b0}}};
            RS_MODE: load_val = {mode_q, {PAD_W{1'b0}}};
            RS_RSVD: load_val = '0;
            default: load_val = data_q;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CMD: begin
                if (bit_rise && bit_cnt_q == LAST_BYTE) begin
                    if (cont_enter)                  state_d = ST_CONT;
                    else if (byte_in[3])             state_d = ST_RD;
                    else if (byte_in[5:4] != RS_STAT) state_d = ST_WR;
                end
            end
            ST_WR, ST_RD: begin
                if (!cs_act || (bit_rise && at_last)) state_d = ST_CMD;
            end
            ST_CONT: begin
                if (cont_exit) state_d = ST_CMD;
            end
            default: state_d = ST_CMD;
        endcase
        if (srst) state_d = ST_CMD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CMD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            last_q    <= LAST_BYTE;
            sel_q     <= RS_STAT;
            chan_q    <= 2'b00;
            cmd_sh_q  <= '0;
            shift_q   <= '0;
            live_q    <= 1'b0;
            restart_q <= 1'b0;
            mode_q    <= 8'h00;
        end else if (srst) begin
            bit_cnt_q <= '0;
            last_q    <= LAST_BYTE;
            sel_q     <= RS_STAT;
            chan_q    <= 2'b00;
            cmd_sh_q  <= '0;
            shift_q   <= '0;
            live_q    <= 1'b0;
            restart_q <= 1'b0;
            mode_q    <= 8'h00;
        end else begin
            restart_q <= 1'b0;
            if (!cs_act) begin
                bit_cnt_q <= '0;
                live_q    <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_CMD: begin
                        if (bit_rise && !(bit_cnt_q == '0 && din_s)) begin
                            if (bit_cnt_q == LAST_BYTE) begin
                                bit_cnt_q <= '0;
                                chan_q    <= byte_in[1:0];
                                restart_q <= (byte_in[1:0] != chan_q);
                                sel_q     <= byte_in[5:4];
                                last_q    <= (byte_in[3] && byte_in[5:4] == RS_DATA) ?
                                             LAST_WORD : LAST_BYTE;
                                if (byte_in[3] && !cont_enter) begin
                                    shift_q <= load_val;
                                    live_q  <= 1'b1;
                                end
                            end else begin
                                cmd_sh_q  <= {cmd_sh_q[5:0], din_s};
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_WR: begin
                        if (bit_rise) begin
                            if (at_last) begin
                                bit_cnt_q <= '0;
                                if (sel_q == RS_MODE) mode_q <= byte_in;
                            end else begin
                                cmd_sh_q  <= {cmd_sh_q[5:0], din_s};
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_RD: begin
                        if (bit_rise) begin
                            shift_q <= shift_q << 1;
                            if (at_last) begin
                                bit_cnt_q <= '0;
                                live_q    <= 1'b0;
                            end else begin
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_CONT: begin
                        if (live_q && bit_rise) begin
                            shift_q  <= shift_q << 1;
                            cmd_sh_q <= {cmd_sh_q[5:0], din_s};
                            if (cont_exit || bit_cnt_q == LAST_WORD) begin
                                bit_cnt_q <= '0;
                                live_q    <= 1'b0;
                            end else begin
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end else if (!live_q && !rdy_n) begin
                            shift_q <= data_q;
                            live_q  <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign dout         = live_q ? shift_q[DATA_W-1] : rdy_n;
    assign dout_oe      = cs_act;
    assign mode_cfg     = mode_q;
    assign chan_sel     = chan_q;
    assign chan_restart = restart_q;

    // R11
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (bit_cnt_q == '0));

    // R8
    live_only_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (state_q == ST_RD || state_q == ST_CONT));

    // R5
    restart_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_restart |-> (chan_q != $past(chan_q)));

    // R9
    exit_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cont_exit |-> !rdy_n);
endmodule

// File: tb/test_adc_serial_ctrl.sv
module test_adc_serial_ctrl;
    localparam int DW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic conv_done = 1'b0;
    logic [DW-1:0] conv_result = '0;
    logic dout, dout_oe, chan_restart;
    logic [7:0] mode_cfg;
    logic [1:0] chan_sel;

    int total = 0, fails = 0, restarts = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    logic [31:0] act_word;
    event got_ev;

    always #10 clk = ~clk;

    adc_serial_ctrl #(.DATA_W(DW), .RUN_LEN(32)) i_adc_serial_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_oe(dout_oe), .conv_done(conv_done),
        .conv_result(conv_result), .mode_cfg(mode_cfg), .chan_sel(chan_sel),
        .chan_restart(chan_restart)
    );

    always @(posedge clk) if (chan_restart) restarts++;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input int n, input logic [31:0] v, output logic [31:0] cap);
        cap = '0;
        for (int i = n - 1; i >= 0; i--) begin
            din = v[i];
            wait_clk(6);
            cap[i] = dout;
            sclk = 1'b1;
            wait_clk(6);
            sclk = 1'b0;
        end
        wait_clk(6);
        din = 1'b0;
    endtask

    task automatic expect_word(input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic publish(input logic [31:0] w);
        act_word = w;
        -> got_ev;
        wait_clk(1);
    endtask

    task automatic rd(input logic [7:0] cmd, input int n, input logic [31:0] exp, input string tag);
        logic [31:0] c;
        expect_word(exp, tag);
        xfer(8, {24'd0, cmd}, c);
        xfer(n, 32'd0, c);
        publish(c);
    endtask

    task automatic new_result(input logic [DW-1:0] v);
        conv_result = v;
        conv_done = 1'b1;
        wait_clk(1);
        conv_done = 1'b0;
        wait_clk(4);
    endtask

    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                total++;
                fails++;
                $display("FAIL unexpected word: actual %h expected none", act_word);
            end else begin
                chk(tag_q.pop_front(), act_word, exp_q.pop_front());
            end
        end
    end

    initial begin
        logic [31:0] c, hi, lo;
        int r0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R1 oe off", {31'd0, dout_oe}, 32'd0);
        chk("R1 mode port", {24'd0, mode_cfg}, 32'h00);
        chk("R1 chan port", {30'd0, chan_sel}, 32'd0);
        cs_n = 1'b0;
        wait_clk(6);
        chk("R1 oe on", {31'd0, dout_oe}, 32'd1);
        chk("R1 idle ready high", {31'd0, dout}, 32'd1);
        rd(8'h08, 8, 32'h88, "R1 R3 status");
        rd(8'h18, 8, 32'h00, "R1 mode read");

        xfer(3, 32'h7, c);
        xfer(8, 32'h10, c);
        xfer(8, 32'hA5, c);
        chk("R4 mode port", {24'd0, mode_cfg}, 32'hA5);
        rd(8'h18, 8, 32'hA5, "R2 R4 mode after leading ones");
        rd(8'h28, 8, 32'h00, "R3 reserved");

        r0 = restarts;
        xfer(8, 32'h03, c);
        chk("R5 chan set", {30'd0, chan_sel}, 32'd3);
        chk("R5 restart once", restarts - r0, 32'd1);
        xfer(8, 32'h03, c);
        chk("R5 no restart same chan", restarts - r0, 32'd1);
        rd(8'h0B, 8, 32'h8B, "R3 status with chan");

        new_result(24'h800123);
        chk("R6 ready low", {31'd0, dout}, 32'd0);
        rd(8'h3B, 24, 32'h800123, "R6 data read");
        chk("R6 ready high after read", {31'd0, dout}, 32'd1);

        new_result(24'h123456);
        expect_word(32'h123456, "R7 coherent word");
        xfer(8, 32'h3B, c);
        xfer(8, 32'd0, hi);
        new_result(24'hABCDEF);
        xfer(16, 32'd0, lo);
        publish({8'd0, hi[7:0], lo[15:0]});
        chk("R7 held result ready", {31'd0, dout}, 32'd0);
        rd(8'h3B, 24, 32'hABCDEF, "R7 held result read");

        xfer(4, 32'h3, c);
        cs_n = 1'b1;
        wait_clk(6);
        chk("R11 oe off", {31'd0, dout_oe}, 32'd0);
        cs_n = 1'b0;
        wait_clk(6);
        rd(8'h1B, 8, 32'hA5, "R11 after abort");

        new_result(24'h0F0F0F);
        xfer(8, 32'h3F, c);
        expect_word(32'h0F0F0F, "R8 stream word 1");
        xfer(24, 32'd0, c);
        publish(c);
        chk("R8 ready high after word", {31'd0, dout}, 32'd1);
        new_result(24'h654321);
        expect_word(32'h654321, "R8 stream word 2");
        xfer(24, 32'd0, c);
        publish(c);

        new_result(24'hC3C3C3);
        expect_word(32'hC3, "R9 exit byte data");
        xfer(8, 32'h3B, c);
        publish(c);
        rd(8'h0B, 8, 32'h0B, "R9 back in command mode");

        xfer(32, 32'hFFFF_FFFF, c);
        wait_clk(4);
        chk("R10 chan reset", {30'd0, chan_sel}, 32'd0);
        chk("R10 mode port reset", {24'd0, mode_cfg}, 32'h00);
        chk("R10 ready reset", {31'd0, dout}, 32'd1);
        rd(8'h18, 8, 32'h00, "R10 mode read");
        rd(8'h08, 8, 32'h88, "R10 status read");

        wait_clk(10);
        if (exp_q.size() != 0) begin
            total++;
            fails++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule